// File: doc/BRIEF.md
# Integer ALU with Branch Flags

This block is the purely combinational integer arithmetic unit of a 32-bit in-order pipeline. It takes two operands and a packed 16-bit control word and returns one 32-bit result together with three comparison flags. The branch logic reads the flags, and the register writeback path reads the result.

A single adder serves addition, subtraction, set-on-less-than and upper-half immediate loads. Before the adder, the second operand passes through a four-way pre-select, and the low bit of that select doubles as the carry-in. Beside the adder sit three other units:

- a bitwise logic unit with an optional output inversion;
- a barrel shifter with left, logical-right and arithmetic-right modes;
- a comparator with its own subtractor, so the flags are valid whatever the result controls say.

The clock and active-low reset ports are not used by the datapath. They exist only so that clocked checks can sample the block.

Control word fields, from MSB to LSB:

| Field | Width | Meaning |
|---|---|---|
| `use_slt` | 1 | Select the set-on-less-than result |
| `cmp_unsigned` | 1 | Compare unsigned instead of signed |
| `use_arith` | 1 | Select the adder result |
| `use_logic` | 1 | Select the logic unit result |
| `logic_inv` | 1 | Invert the logic unit result |
| `logic_sel` | 2 | Choose the bitwise operation |
| `addend_sel` | 2 | Choose the adder's second input; bit 0 is also the carry-in |
| `shift_kind` | 2 | Choose the shift mode |
| `shamt` | 5 | Shift amount |

Top module: `int_alu_core`

## Requirements
- R1: With `addend_sel` = 00 and the adder result selected, the result is op_a + op_b modulo 2^32. A carry out of bit 31 is dropped silently and raises no trap.
- R2: With `addend_sel` = 01 the adder adds the bitwise inverse of op_b with a carry-in of 1, so the result is op_a - op_b modulo 2^32.
- R3: With `addend_sel` = 10 the result is op_a + (op_b << 16). With `addend_sel` = 11 the second input is zero but the carry-in is still 1, so the result is op_a + 1.
- R4: When the logic result is selected, `logic_sel` 00 gives op_a AND op_b, 01 gives OR, 10 gives XOR, and 11 gives all zeros.
- R5: When `logic_inv` is 1, the logic unit output is inverted. With `logic_sel` = 01 this yields NOR.
- R6: When none of the other sources is selected, the result is op_b shifted by `shamt` (0 to 31). `shift_kind` 00 and 01 shift left with zero fill, 10 shifts right with zero fill, and 11 shifts right filling with op_b bit 31.
- R7: When `use_slt` is set, the result is 1 if op_a < op_b, else 0. Bits 31..1 of the result are always zero.
- R8: Result sources follow a fixed priority: `use_slt` first, then `use_arith`, then `use_logic`, then the shifter.
- R9: `flag_neg` equals op_a bit 31 and `flag_eq` is 1 exactly when op_a equals op_b. `flag_lt` is 1 when op_a < op_b, compared signed when `cmp_unsigned` = 0 and unsigned when it is 1.
- R10: The signed less-than comparison is correct when the operand signs differ and the raw difference overflows. For example, 0x80000000 < 0x7FFFFFFF is true and 0x7FFFFFFF < 0x80000000 is false.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the bound checks; unused by the datapath |
| rst_n | input | 1 | Active-low synchronous reset; gates the checks only |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand; the value pre-selected for the adder and the value shifted |
| ctrl | input | 16 | Packed control word (field order above) |
| result | output | 32 | Selected result |
| flag_neg | output | 1 | op_a is negative |
| flag_eq | output | 1 | op_a equals op_b |
| flag_lt | output | 1 | op_a is less than op_b, signed or unsigned per the control word |

## Verification
The checks sample the ports on the rising clock edge and compare the result against arithmetic reference expressions. They therefore assume that operands and control have settled well before that edge and stay put across it. They place no other limits on operand values or field combinations, because every control encoding has a defined result. The bench changes all inputs only on the falling edge and holds them for the whole following rising edge, so every sampled value reflects one complete input set.

// File: rtl/alu_pkg.sv
// Package: alu_pkg
// Shared widths and the packed control record of the integer ALU.
// Assumes a power-of-two datapath width.
package alu_pkg;

    parameter int ALU_W   = 32;
    parameter int SHAMT_W = $clog2(ALU_W);

    // Adder second-input choices; bit 0 doubles as carry-in.
    typedef enum logic [1:0] {
        ADD_PASS = 2'b00,
        ADD_INV  = 2'b01,
        ADD_HI   = 2'b10,
        ADD_ZERO = 2'b11
    } addend_sel_e;

    typedef struct packed {
        logic               use_slt;
        logic               cmp_unsigned;
        logic               use_arith;
        logic               use_logic;
        logic               logic_inv;
        logic [1:0]         logic_sel;
        logic [1:0]         addend_sel;
        logic [1:0]         shift_kind;
        logic [SHAMT_W-1:0] shamt;
    } alu_ctrl_t;

    localparam int CTRL_W = $bits(alu_ctrl_t);

endpackage

// File: rtl/alu_addend_adder.sv
// Module: alu_addend_adder
// Pre-selects the second adder input (pass, invert, shift up by half
// the width, zero) and adds it to the first operand. The carry-in is
// bit 0 of the select. The sum wraps; no carry or overflow is reported.
module alu_addend_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       sel,
    output logic [WIDTH-1:0] sum
);
    localparam int HALF = WIDTH / 2;

    logic [WIDTH-1:0] addend;

    // Choose the second adder input.
    always_comb begin
        case (sel)
            2'b00:   addend = b;
            2'b01:   addend = ~b;
            2'b10:   addend = b << HALF;
            default: addend = '0;
        endcase
    end

    // Modular sum with the select's low bit as carry-in.
    always_comb begin
        sum = a + addend + {{(WIDTH-1){1'b0}}, sel[0]};
    end

endmodule

// File: rtl/alu_compare.sv
// Module: alu_compare
// Produces the branch flags from its own subtractor, independent of the
// result controls. Signed less-than uses the operand sign bits when they
// differ and the difference sign otherwise; unsigned uses the borrow.
module alu_compare #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             is_unsigned,
    output logic             neg,
    output logic             eq,
    output logic             lt
);
    logic [WIDTH:0] diff;
    logic           borrow;
    logic           signed_lt;

    // Full-width difference with carry out.
    always_comb begin
        diff   = {1'b0, a} + {1'b0, ~b} + {{WIDTH{1'b0}}, 1'b1};
        borrow = ~diff[WIDTH];
    end

    // Signed ordering robust against difference overflow.
    always_comb begin
        if (a[WIDTH-1] != b[WIDTH-1]) signed_lt = a[WIDTH-1];
        else                          signed_lt = diff[WIDTH-1];
    end

    // Flag outputs.
    always_comb begin
        neg = a[WIDTH-1];
        eq  = (diff[WIDTH-1:0] == '0);
        lt  = is_unsigned ? borrow : signed_lt;
    end

endmodule

// File: rtl/alu_logic_unit.sv
// Module: alu_logic_unit
// Bitwise AND / OR / XOR (select 11 gives zero) with optional inversion
// of the output, which turns OR into NOR.
module alu_logic_unit #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       sel,
    input  logic             inv,
    output logic [WIDTH-1:0] y
);
    logic [WIDTH-1:0] raw;

    // Pick the bitwise operation.
    always_comb begin
        case (sel)
            2'b00:   raw = a & b;
            2'b01:   raw = a | b;
            2'b10:   raw = a ^ b;
            default: raw = '0;
        endcase
    end

    // Optional inversion.
    always_comb begin
        y = inv ? ~raw : raw;
    end

endmodule

// File: rtl/alu_barrel_shifter.sv
// Module: alu_barrel_shifter
// Logarithmic right shifter; left shifts reverse the bits on the way in
// and out. kind[1] selects right, kind[0] selects sign fill for right
// shifts only. Assumes WIDTH is a power of two.
module alu_barrel_shifter #(
    parameter int WIDTH = 32,
    parameter int SHW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] value,
    input  logic [SHW-1:0]   amount,
    input  logic [1:0]       kind,
    output logic [WIDTH-1:0] y
);
    logic             go_right;
    logic             fill;
    logic [WIDTH-1:0] rev_in;
    logic [WIDTH-1:0] rev_out;
    logic [WIDTH-1:0] stg [0:SHW];

    // Direction and fill bit.
    always_comb begin
        go_right = kind[1];
        fill     = kind[1] & kind[0] & value[WIDTH-1];
    end

    // Bit reversal networks for left shifts.
    for (genvar k = 0; k < WIDTH; k++) begin : g_rev
        assign rev_in[k] = value[WIDTH-1-k];
        assign rev_out[k] = stg[SHW][WIDTH-1-k];
    end

    assign stg[0] = go_right ? value : rev_in;

    // One conditional right-shift stage per amount bit.
    for (genvar i = 0; i < SHW; i++) begin : g_stage
        localparam int STEP = 1 << i;
        assign stg[i+1] = amount[i] ? {{STEP{fill}}, stg[i][WIDTH-1:STEP]}
                                    : stg[i];
    end

    assign y = go_right ? stg[SHW] : rev_out;

endmodule

// File: rtl/int_alu_core.sv
// Module: int_alu_core
// Combinational integer ALU: adder with pre-selected second input,
// logic unit, barrel shifter and comparator. Result priority is
// set-on-less-than, adder, logic, shifter. clk/rst_n only serve the
// bound checker.
module int_alu_core
    import alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ALU_W-1:0]  op_a,
    input  logic [ALU_W-1:0]  op_b,
    input  logic [CTRL_W-1:0] ctrl,
    output logic [ALU_W-1:0]  result,
    output logic              flag_neg,
    output logic              flag_eq,
    output logic              flag_lt
);
    alu_ctrl_t        c;
    logic [ALU_W-1:0] sum_y;
    logic [ALU_W-1:0] logic_y;
    logic [ALU_W-1:0] shift_y;
    logic             lt_int;

    assign c = alu_ctrl_t'(ctrl);

    alu_addend_adder #(.WIDTH(ALU_W)) u_add (
        .a   (op_a),
        .b   (op_b),
        .sel (c.addend_sel),
        .sum (sum_y)
    );

    alu_logic_unit #(.WIDTH(ALU_W)) u_logic (
        .a   (op_a),
        .b   (op_b),
        .sel (c.logic_sel),
        .inv (c.logic_inv),
        .y   (logic_y)
    );

    alu_barrel_shifter #(.WIDTH(ALU_W), .SHW(SHAMT_W)) u_shift (
        .value  (op_b),
        .amount (c.shamt),
        .kind   (c.shift_kind),
        .y      (shift_y)
    );

    alu_compare #(.WIDTH(ALU_W)) u_cmp (
        .a           (op_a),
        .b           (op_b),
        .is_unsigned (c.cmp_unsigned),
        .neg         (flag_neg),
        .eq          (flag_eq),
        .lt          (lt_int)
    );

    assign flag_lt = lt_int;

    // Priority result select.
    always_comb begin
        if (c.use_slt)        result = {{(ALU_W-1){1'b0}}, lt_int};
        else if (c.use_arith) result = sum_y;
        else if (c.use_logic) result = logic_y;
        else                  result = shift_y;
    end

endmodule

// File: rtl/alu_checker.sv
// Module: alu_checker
// Clocked properties over the ALU ports, sampled on the rising edge.
// Assumes inputs are stable around that edge.
module alu_checker
    import alu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ALU_W-1:0]  op_a,
    input logic [ALU_W-1:0]  op_b,
    input logic [CTRL_W-1:0] ctrl,
    input logic [ALU_W-1:0]  result,
    input logic              flag_neg,
    input logic              flag_eq,
    input logic              flag_lt
);
    alu_ctrl_t c;
    logic      arith_on;
    logic      logic_on;
    logic      shift_on;

    // Decode which source should be visible.
    always_comb begin
        c        = alu_ctrl_t'(ctrl);
        arith_on = !c.use_slt && c.use_arith;
        logic_on = !c.use_slt && !c.use_arith && c.use_logic;
        shift_on = !c.use_slt && !c.use_arith && !c.use_logic;
    end

    AST_ADD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (arith_on && c.addend_sel == 2'b00) |-> result == op_a + op_b); // R1
    AST_SUB_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (arith_on && c.addend_sel == 2'b01) |-> result == op_a - op_b); // R2
    AST_ZERO_ADDEND: assert property (@(posedge clk) disable iff (!rst_n)
        (arith_on && c.addend_sel == 2'b11) |-> result == op_a + 1); // R3
    AST_NOR_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (logic_on && c.logic_inv && c.logic_sel == 2'b01) |-> result == ~(op_a | op_b)); // R5
    AST_LEFT_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_on && c.shift_kind == 2'b00) |-> result == (op_b << c.shamt)); // R6
    AST_SLT_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        c.use_slt |-> result[ALU_W-1:1] == '0); // R7
    AST_EQ_NOT_LT: assert property (@(posedge clk) disable iff (!rst_n)
        flag_eq |-> !flag_lt); // R9
    AST_UNSIGNED_LT: assert property (@(posedge clk) disable iff (!rst_n)
        c.cmp_unsigned |-> flag_lt == (op_a < op_b)); // R9
    AST_SIGNED_LT: assert property (@(posedge clk) disable iff (!rst_n)
        !c.cmp_unsigned |-> flag_lt == ($signed(op_a) < $signed(op_b))); // R10

endmodule

bind int_alu_core alu_checker u_alu_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_a     (op_a),
    .op_b     (op_b),
    .ctrl     (ctrl),
    .result   (result),
    .flag_neg (flag_neg),
    .flag_eq  (flag_eq),
    .flag_lt  (flag_lt)
);

// File: tb/tb_int_alu_core.sv
// Bench: directed scenarios, one task each, for int_alu_core.
module tb_int_alu_core;
    import alu_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ALU_W-1:0]  op_a = '0;
    logic [ALU_W-1:0]  op_b = '0;
    logic [CTRL_W-1:0] ctrl = '0;
    logic [ALU_W-1:0]  result;
    logic              flag_neg;
    logic              flag_eq;
    logic              flag_lt;

    int n_tests = 0;
    int n_fail  = 0;

    int_alu_core dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_a     (op_a),
        .op_b     (op_b),
        .ctrl     (ctrl),
        .result   (result),
        .flag_neg (flag_neg),
        .flag_eq  (flag_eq),
        .flag_lt  (flag_lt)
    );

    always #5 clk = ~clk;

    // Compare one value against its expectation.
    task automatic chk(input string tag, input logic [ALU_W-1:0] got,
                       input logic [ALU_W-1:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    // Apply inputs on the falling edge and let them settle.
    task automatic apply(input alu_ctrl_t c, input logic [ALU_W-1:0] a,
                         input logic [ALU_W-1:0] b);
        @(negedge clk);
        ctrl = CTRL_W'(c);
        op_a = a;
        op_b = b;
        #2;
    endtask

    function automatic alu_ctrl_t arith(input logic [1:0] sel);
        alu_ctrl_t c = '0;
        c.use_arith  = 1'b1;
        c.addend_sel = sel;
        return c;
    endfunction

    function automatic alu_ctrl_t logic_op(input logic [1:0] sel, input logic inv);
        alu_ctrl_t c = '0;
        c.use_logic = 1'b1;
        c.logic_sel = sel;
        c.logic_inv = inv;
        return c;
    endfunction

    function automatic alu_ctrl_t shift_op(input logic [1:0] kind, input int amt);
        alu_ctrl_t c = '0;
        c.shift_kind = kind;
        c.shamt      = SHAMT_W'(amt);
        return c;
    endfunction

    function automatic alu_ctrl_t slt_op(input logic uns);
        alu_ctrl_t c = '0;
        c.use_slt      = 1'b1;
        c.cmp_unsigned = uns;
        return c;
    endfunction

    task automatic t_reset_state();
        @(negedge clk);
        #2;
        chk("reset result R6", result, 32'h0);
        chk("reset flag_eq R9", {31'b0, flag_eq}, 32'h1);
        chk("reset flag_lt R9", {31'b0, flag_lt}, 32'h0);
    endtask

    task automatic t_add();
        apply(arith(2'b00), 32'hFFFF_FFFF, 32'h2);
        chk("R1 wrap", result, 32'h1);
        apply(arith(2'b00), 32'h1234_5678, 32'h1111_1111);
        chk("R1 add", result, 32'h2345_6789);
    endtask

    task automatic t_sub();
        apply(arith(2'b01), 32'd5, 32'd7);
        chk("R2 negative diff", result, 32'hFFFF_FFFE);
        apply(arith(2'b01), 32'h8000_0000, 32'h1);
        chk("R2 wrap diff", result, 32'h7FFF_FFFF);
    endtask

    task automatic t_addend_modes();
        apply(arith(2'b10), 32'h0000_00AA, 32'h0000_1234);
        chk("R3 high-half addend", result, 32'h1234_00AA);
        apply(arith(2'b11), 32'hFFFF_FFFF, 32'h5555_5555);
        chk("R3 zero addend plus carry", result, 32'h0);
    endtask

    task automatic t_logic();
        logic [ALU_W-1:0] a = 32'hF0F0_1234;
        logic [ALU_W-1:0] b = 32'hFF00_00FF;
        apply(logic_op(2'b00, 1'b0), a, b);
        chk("R4 and", result, a & b);
        apply(logic_op(2'b01, 1'b0), a, b);
        chk("R4 or", result, a | b);
        apply(logic_op(2'b10, 1'b0), a, b);
        chk("R4 xor", result, a ^ b);
        apply(logic_op(2'b11, 1'b0), a, b);
        chk("R4 zero code", result, 32'h0);
        apply(logic_op(2'b01, 1'b1), a, b);
        chk("R5 nor", result, ~(a | b));
        apply(logic_op(2'b10, 1'b1), a, b);
        chk("R5 inverted xor", result, ~(a ^ b));
    endtask

    task automatic t_shift();
        apply(shift_op(2'b00, 31), 32'h0, 32'h1);
        chk("R6 sll 31", result, 32'h8000_0000);
        apply(shift_op(2'b01, 4), 32'h0, 32'h0000_00F1);
        chk("R6 code 01 left", result, 32'h0000_0F10);
        apply(shift_op(2'b10, 4), 32'h0, 32'h8000_0000);
        chk("R6 srl", result, 32'h0800_0000);
        apply(shift_op(2'b11, 4), 32'h0, 32'h8000_0000);
        chk("R6 sra negative", result, 32'hF800_0000);
        apply(shift_op(2'b11, 30), 32'h0, 32'h4000_0000);
        chk("R6 sra positive", result, 32'h1);
        apply(shift_op(2'b11, 0), 32'h0, 32'hDEAD_BEEF);
        chk("R6 amount zero", result, 32'hDEAD_BEEF);
    endtask

    task automatic t_slt();
        apply(slt_op(1'b0), 32'hFFFF_FFFF, 32'h1);
        chk("R7 signed -1<1", result, 32'h1);
        apply(slt_op(1'b1), 32'hFFFF_FFFF, 32'h1);
        chk("R7 unsigned max<1", result, 32'h0);
        apply(slt_op(1'b0), 32'h42, 32'h42);
        chk("R7 equal", result, 32'h0);
        apply(slt_op(1'b0), 32'h8000_0000, 32'h7FFF_FFFF);
        chk("R10 min<max signed", result, 32'h1);
        apply(slt_op(1'b0), 32'h7FFF_FFFF, 32'h8000_0000);
        chk("R10 max<min signed", result, 32'h0);
        apply(slt_op(1'b1), 32'h7FFF_FFFF, 32'h8000_0000);
        chk("R10 max<min unsigned", result, 32'h1);
    endtask

    task automatic t_priority();
        alu_ctrl_t c;
        c = '0;
        c.use_slt = 1'b1; c.use_arith = 1'b1; c.use_logic = 1'b1;
        c.logic_sel = 2'b01;
        apply(c, 32'd3, 32'd9);
        chk("R8 slt wins", result, 32'h1);
        c.use_slt = 1'b0;
        apply(c, 32'd3, 32'd9);
        chk("R8 arith over logic", result, 32'd12);
        c.use_arith = 1'b0;
        apply(c, 32'd3, 32'd9);
        chk("R8 logic over shift", result, 32'd11);
        c.use_logic = 1'b0;
        c.shamt = 5'd2;
        apply(c, 32'd3, 32'd9);
        chk("R8 shift fallback", result, 32'd36);
    endtask

    task automatic t_flags();
        alu_ctrl_t c = '0;
        apply(c, 32'h8000_0001, 32'h5);
        chk("R9 neg set", {31'b0, flag_neg}, 32'h1);
        chk("R9 lt signed", {31'b0, flag_lt}, 32'h1);
        chk("R9 eq clear", {31'b0, flag_eq}, 32'h0);
        c.cmp_unsigned = 1'b1;
        apply(c, 32'h8000_0001, 32'h5);
        chk("R9 lt unsigned", {31'b0, flag_lt}, 32'h0);
        apply(c, 32'h3, 32'h3);
        chk("R9 eq set", {31'b0, flag_eq}, 32'h1);
        chk("R9 neg clear", {31'b0, flag_neg}, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_add();
        t_sub();
        t_addend_modes();
        t_logic();
        t_shift();
        t_slt();
        t_priority();
        t_flags();
        repeat (2) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        #200000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule